// File: doc/BRIEF.md
# Pipelined Floating-Point Significand Multiplier

This block multiplies two IEEE-754 binary operands and returns the product in an expanded, unrounded form. The operand width is a parameter and may be 32 or 64 bits. The output has three parts: the result sign, a widened two's-complement exponent, and the complete significand product. The product is twice as wide as an operand significand, with the hidden bit counted, so no product bit is lost. Its top two bits are integer bits, which means the product value lies in [0,4). A normalising stage and a rounding stage placed after this block finish the result.

Denormal operands are used exactly as they are and are never flushed to zero. Special operand combinations (NaN, infinity, zero, and infinity times zero) are resolved inside the pipeline and reported on four flag outputs. A three-bit rounding mode enters with the operands and leaves with the matching product. The block does not use it. The pipeline advances only on cycles where the clock enable is high.

Top module: `fpm_mul_top`

## Requirements
- R1: While reset is asserted, and until five enabled cycles after it is released, every output is zero. This covers sign, exponent, significand, rounding mode and all four flags.
- R2: For two normal finite operands, res_man equals the product of the two significands with the hidden 1 restored. It is 2*(MW+1) bits wide, and its top two bits are the integer bits. The result appears after 5 enabled clock edges.
- R3: A denormal operand is multiplied with hidden bit 0 and effective exponent 1, and the product is not flushed to zero.
- R4: For a numeric result, res_exp equals effA + effB - bias, with bias = 2^(EW-1)-1. It is given as an (EW+2)-bit two's-complement value, so results below 1 and above the exponent range of the format can be represented.
- R5: res_sign is the XOR of the two operand signs for every result, including zero, infinity and NaN.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), then flag_nan is 1 and res_exp is 2^EW-1. res_man has only bit 2*(MW+1)-3 set, which is the quiet bit just below the integer bits.
- R7: Infinity times zero, in either order, sets both flag_nan and flag_invalid and produces the same quiet NaN pattern as R6. flag_invalid is never set without flag_nan, and at most one of flag_nan, flag_inf and flag_zero is set at a time.
- R8: Infinity times a nonzero finite value or infinity, with no NaN involved, sets flag_inf. res_exp is then 2^EW-1 and res_man is 0.
- R9: Zero times a finite value sets flag_zero. res_exp and res_man are then both 0.
- R10: While ce is low, every pipeline register holds its value and the outputs do not change. Operands that were inside the pipeline come out in order once ce returns high.
- R11: rm_out is the rm input delayed by the same 5 enabled cycles. rm has no effect on the product.
- R12: Instances with FW=32 (EW=8, MW=23) and FW=64 (EW=11, MW=52) both meet R1 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; the pipeline advances only while it is high |
| rm | input | 3 | Rounding mode, carried along with the operands |
| op_a | input | FW | First IEEE-754 operand |
| op_b | input | FW | Second IEEE-754 operand |
| res_sign | output | 1 | Product sign |
| res_exp | output | EW+2 | Unbiased-adjusted exponent, two's complement |
| res_man | output | 2*(MW+1) | Full significand product, two integer bits |
| rm_out | output | 3 | Rounding mode aligned with the result |
| flag_nan | output | 1 | Result is a quiet NaN |
| flag_inf | output | 1 | Result is infinity |
| flag_zero | output | 1 | Result is zero |
| flag_invalid | output | 1 | Infinity times zero occurred |

## Verification
The hardest case to reach from the ports is a stall that lands while denormal and special-class operands are spread over several stages at once. In that case the sideband class information and the split partial products must stay aligned across the freeze. The stimulus first sends a directed run of denormal and special pairs with single-cycle enable drops between them. It then runs a long random phase in which roughly one cycle in four is stalled and about a third of the operands are denormal, zero, infinite or NaN. A queue model restates the arithmetic with plain wide integers and is compared against both widths on every clock.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    CLS_FIN  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpm_cls_e;

  typedef enum logic [1:0] {
    RK_NUM  = 2'd0,
    RK_ZERO = 2'd1,
    RK_INF  = 2'd2,
    RK_NAN  = 2'd3
  } fpm_kind_e;

  typedef struct packed {
    fpm_kind_e kind;
    logic      invalid;
  } fpm_sel_t;

  // Resolve the result class from the two operand classes.
  function automatic fpm_sel_t fpm_combine(input fpm_cls_e ca, input fpm_cls_e cb);
    fpm_sel_t r;
    r.kind    = RK_NUM;
    r.invalid = 1'b0;
    if (ca == CLS_NAN || cb == CLS_NAN) begin
      r.kind = RK_NAN;
    end else if ((ca == CLS_INF && cb == CLS_ZERO) || (ca == CLS_ZERO && cb == CLS_INF)) begin
      r.kind    = RK_NAN;
      r.invalid = 1'b1;
    end else if (ca == CLS_INF || cb == CLS_INF) begin
      r.kind = RK_INF;
    end else if (ca == CLS_ZERO || cb == CLS_ZERO) begin
      r.kind = RK_ZERO;
    end
    return r;
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int FW = 32,
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [FW-1:0] op,
  output logic          sign,
  output logic [MW:0]   sig,
  output logic [EW-1:0] eexp,
  output fpm_cls_e      cls
);

  logic [EW-1:0] field_e;
  logic [MW-1:0] field_f;
  logic          e_zero;
  logic          e_ones;
  logic          f_zero;

  assign field_e = op[FW-2 -: EW];
  assign field_f = op[MW-1:0];
  assign e_zero  = (field_e == '0);
  assign e_ones  = &field_e;
  assign f_zero  = (field_f == '0);

  assign sign = op[FW-1];
  // Denormal: hidden bit 0, effective exponent 1.
  assign sig  = {~e_zero, field_f};
  assign eexp = e_zero ? EW'(1) : field_e;

  always_comb begin
    if (e_ones)
      cls = f_zero ? CLS_INF : CLS_NAN;
    else if (e_zero && f_zero)
      cls = CLS_ZERO;
    else
      cls = CLS_FIN;
  end

endmodule

// File: rtl/fpm_pipe.sv
module fpm_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [DEPTH-1:0][W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (ce) begin
      regs[0] <= d;
      for (int i = 1; i < DEPTH; i++) regs[i] <= regs[i-1];
    end
  end

  assign q = regs[DEPTH-1];

endmodule

// File: rtl/fpm_mul_core.sv
module fpm_mul_core #(
  parameter int SW = 24,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  output logic [2*SW-1:0] p
);

  localparam int PW  = 2 * SW;
  localparam int LW  = (SW + NS - 1) / NS;
  localparam int YPW = NS * LW;
  localparam int PPW = SW + LW;

  logic [YPW-1:0] y_pad;
  logic [PW-1:0]  acc [NS+1];
  logic [PW-1:0]  p_r;

  assign y_pad  = YPW'(y);
  assign acc[0] = '0;

  // Stage A: one registered partial product per slice of y.
  for (genvar g = 0; g < NS; g++) begin : g_slice
    logic [PPW-1:0] pp_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pp_r <= '0;
      else if (ce)
        pp_r <= PPW'(x) * PPW'(y_pad[g*LW +: LW]);
    end
    assign acc[g+1] = acc[g] + (PW'(pp_r) << (g * LW));
  end

  // Stage B: registered sum of the shifted partial products.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      p_r <= '0;
    else if (ce)
      p_r <= acc[NS];
  end

  assign p = p_r;

  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(p_r)); // R10

endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top
  import fpm_pkg::*;
#(
  parameter int FW = 32,
  parameter int NS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ce,
  input  logic [2:0]                      rm,
  input  logic [FW-1:0]                   op_a,
  input  logic [FW-1:0]                   op_b,
  output logic                            res_sign,
  output logic [((FW == 64) ? 11 : 8)+1:0] res_exp,
  output logic [2*(FW-((FW == 64) ? 11 : 8))-1:0] res_man,
  output logic [2:0]                      rm_out,
  output logic                            flag_nan,
  output logic                            flag_inf,
  output logic                            flag_zero,
  output logic                            flag_invalid
);

  localparam int EW   = (FW == 64) ? 11 : 8;
  localparam int MW   = FW - 1 - EW;
  localparam int SW   = MW + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SBW  = 1 + XW + $bits(fpm_sel_t);
  localparam int RM_LAT = 5;

  localparam logic [XW-1:0] EXP_ONES = XW'({EW{1'b1}});
  localparam logic [PW-1:0] QNAN_MAN = PW'(1) << (PW - 3);

  function automatic logic [XW-1:0] exp_join(input logic [EW-1:0] ea, input logic [EW-1:0] eb);
    return XW'(ea) + XW'(eb) - XW'(BIAS);
  endfunction

  // ---------------- decode ----------------
  logic [FW-1:0] ops   [2];
  logic          sgn_w [2];
  logic [MW:0]   sig_w [2];
  logic [EW-1:0] eex_w [2];
  fpm_cls_e      cls_w [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpm_unpack #(.FW(FW), .EW(EW), .MW(MW)) u_unp (
      .op   (ops[g]),
      .sign (sgn_w[g]),
      .sig  (sig_w[g]),
      .eexp (eex_w[g]),
      .cls  (cls_w[g])
    );
  end

  fpm_sel_t sel_w;
  assign sel_w = fpm_combine(cls_w[0], cls_w[1]);

  // ---------------- stage 1 ----------------
  logic          s1_sign;
  logic [XW-1:0] s1_exp;
  logic [SW-1:0] s1_siga;
  logic [SW-1:0] s1_sigb;
  fpm_sel_t      s1_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sign <= 1'b0;
      s1_exp  <= '0;
      s1_siga <= '0;
      s1_sigb <= '0;
      s1_sel  <= '0;
    end else if (ce) begin
      s1_sign <= sgn_w[0] ^ sgn_w[1];
      s1_exp  <= exp_join(eex_w[0], eex_w[1]);
      s1_siga <= sig_w[0];
      s1_sigb <= sig_w[1];
      s1_sel  <= sel_w;
    end
  end

  // ---------------- stages 2-3 ----------------
  logic [PW-1:0] s3_prod;

  fpm_mul_core #(.SW(SW), .NS(NS)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .x     (s1_siga),
    .y     (s1_sigb),
    .p     (s3_prod)
  );

  logic [SBW-1:0] s3_side;
  logic           s3_sign;
  logic [XW-1:0]  s3_exp;
  fpm_sel_t       s3_sel;

  fpm_pipe #(.W(SBW), .DEPTH(2)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .d     ({s1_sign, s1_exp, s1_sel}),
    .q     (s3_side)
  );

  assign {s3_sign, s3_exp, s3_sel} = s3_side;

  // ---------------- stage 4: special-value forming ----------------
  logic          f_sign;
  logic [XW-1:0] f_exp;
  logic [PW-1:0] f_man;
  logic          f_nan;
  logic          f_inf;
  logic          f_zero;
  logic          f_inv;

  always_comb begin
    f_sign = s3_sign;
    f_exp  = s3_exp;
    f_man  = s3_prod;
    f_nan  = 1'b0;
    f_inf  = 1'b0;
    f_zero = 1'b0;
    f_inv  = 1'b0;
    unique case (s3_sel.kind)
      RK_NAN: begin
        f_exp = EXP_ONES;
        f_man = QNAN_MAN;
        f_nan = 1'b1;
        f_inv = s3_sel.invalid;
      end
      RK_INF: begin
        f_exp = EXP_ONES;
        f_man = '0;
        f_inf = 1'b1;
      end
      RK_ZERO: begin
        f_exp  = '0;
        f_man  = '0;
        f_zero = 1'b1;
      end
      default: ;
    endcase
  end

  logic          s4_sign;
  logic [XW-1:0] s4_exp;
  logic [PW-1:0] s4_man;
  logic [3:0]    s4_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s4_sign  <= 1'b0;
      s4_exp   <= '0;
      s4_man   <= '0;
      s4_flags <= '0;
    end else if (ce) begin
      s4_sign  <= f_sign;
      s4_exp   <= f_exp;
      s4_man   <= f_man;
      s4_flags <= {f_nan, f_inf, f_zero, f_inv};
    end
  end

  // ---------------- stage 5: output registers ----------------
  logic          s5_sign;
  logic [XW-1:0] s5_exp;
  logic [PW-1:0] s5_man;
  logic [3:0]    s5_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s5_sign  <= 1'b0;
      s5_exp   <= '0;
      s5_man   <= '0;
      s5_flags <= '0;
    end else if (ce) begin
      s5_sign  <= s4_sign;
      s5_exp   <= s4_exp;
      s5_man   <= s4_man;
      s5_flags <= s4_flags;
    end
  end

  fpm_pipe #(.W(3), .DEPTH(RM_LAT)) u_rm (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .d     (rm),
    .q     (rm_out)
  );

  assign res_sign     = s5_sign;
  assign res_exp      = s5_exp;
  assign res_man      = s5_man;
  assign flag_nan     = s5_flags[3];
  assign flag_inf     = s5_flags[2];
  assign flag_zero    = s5_flags[1];
  assign flag_invalid = s5_flags[0];

  // ---------------- assertions ----------------
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_nan, flag_inf, flag_zero})); // R7

  AST_INVALID_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> flag_nan); // R7

  AST_NAN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    flag_nan |-> (res_exp == EXP_ONES && res_man == QNAN_MAN)); // R6

  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero |-> (res_exp == '0 && res_man == '0)); // R9

  AST_INF_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inf |-> (res_exp == EXP_ONES && res_man == '0)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(res_man) && $stable(res_exp) && $stable(res_sign)
             && $stable(s5_flags) && $stable(rm_out))); // R10

endmodule

// File: tb/fpm_mul_top_tb.sv
module fpm_mul_top_tb_top;

  typedef struct {
    logic         sign;
    int           ex;
    logic [105:0] man;
    logic         nan, inf, zero, inv;
    logic [2:0]   rm;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1;
  logic [2:0] rm = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] a64 = '0, b64 = '0;

  logic        s32, s64;
  logic [9:0]  x32;
  logic [12:0] x64;
  logic [47:0] m32;
  logic [105:0] m64;
  logic [2:0]  r32, r64;
  logic n32, i32, z32, v32, n64, i64, z64, v64;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpm_mul_top #(.FW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rm(rm), .op_a(a32), .op_b(b32),
    .res_sign(s32), .res_exp(x32), .res_man(m32), .rm_out(r32),
    .flag_nan(n32), .flag_inf(i32), .flag_zero(z32), .flag_invalid(v32));

  fpm_mul_top #(.FW(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rm(rm), .op_a(a64), .op_b(b64),
    .res_sign(s64), .res_exp(x64), .res_man(m64), .rm_out(r64),
    .flag_nan(n64), .flag_inf(i64), .flag_zero(z64), .flag_invalid(v64));

  // Behavioural reference for one operand pair.
  function automatic exp_t model(input int fw, input logic [63:0] a, input logic [63:0] b,
                                 input logic [2:0] r);
    exp_t e;
    int ew, mw, bias;
    logic [63:0] emax, mmask, ea, eb, fa, fb;
    logic [105:0] sa, sb;
    bit an, bn, ai, bi, az, bz, dn;
    ew = (fw == 32) ? 8 : 11;
    mw = fw - 1 - ew;
    bias = (1 << (ew - 1)) - 1;
    emax = (64'd1 << ew) - 1;
    mmask = (64'd1 << mw) - 1;
    ea = (a >> mw) & emax;  eb = (b >> mw) & emax;
    fa = a & mmask;         fb = b & mmask;
    an = (ea == emax) && (fa != 0);  bn = (eb == emax) && (fb != 0);
    ai = (ea == emax) && (fa == 0);  bi = (eb == emax) && (fb == 0);
    az = (ea == 0) && (fa == 0);     bz = (eb == 0) && (fb == 0);
    dn = ((ea == 0) && (fa != 0)) || ((eb == 0) && (fb != 0));
    e.sign = a[fw-1] ^ b[fw-1];
    e.rm = r; e.man = '0; e.ex = 0;
    e.nan = 0; e.inf = 0; e.zero = 0; e.inv = 0;
    if (an || bn) begin
      e.nan = 1; e.ex = int'(emax); e.man[2*(mw+1)-3] = 1'b1; e.tag = "R6";
    end else if ((ai && bz) || (az && bi)) begin
      e.nan = 1; e.inv = 1; e.ex = int'(emax); e.man[2*(mw+1)-3] = 1'b1; e.tag = "R7";
    end else if (ai || bi) begin
      e.inf = 1; e.ex = int'(emax); e.tag = "R8";
    end else if (az || bz) begin
      e.zero = 1; e.tag = "R9";
    end else begin
      sa = '0; sa[63:0] = fa; if (ea != 0) sa[mw] = 1'b1;
      sb = '0; sb[63:0] = fb; if (eb != 0) sb[mw] = 1'b1;
      e.man = sa * sb;
      e.ex = ((ea == 0) ? 1 : int'(ea)) + ((eb == 0) ? 1 : int'(eb)) - bias;
      e.tag = dn ? "R3" : "R2";
    end
    return e;
  endfunction

  function automatic exp_t zero_exp();
    exp_t e;
    e.sign = 0; e.ex = 0; e.man = '0; e.nan = 0; e.inf = 0; e.zero = 0; e.inv = 0;
    e.rm = '0; e.tag = "R1";
    return e;
  endfunction

  task automatic chk(input string pre, input exp_t e, input logic s, input int ex,
                     input logic [105:0] m, input logic [3:0] fl, input logic [2:0] r);
    logic [3:0] efl;
    bit hold;
    string ts, tx, tr;
    efl = {e.nan, e.inf, e.zero, e.inv};
    hold = (e.tag == "R1") || (e.tag == "R10");
    ts = hold ? e.tag : "R5";
    tx = (e.tag == "R2" || e.tag == "R3") ? "R4" : e.tag;
    tr = hold ? e.tag : "R11";
    checks += 5;
    if (s !== e.sign) begin
      fails++; $display("FAIL %s%s sign actual=%0b expected=%0b", pre, ts, s, e.sign);
    end
    if (ex != e.ex) begin
      fails++; $display("FAIL %s%s exp actual=%0d expected=%0d", pre, tx, ex, e.ex);
    end
    if (m !== e.man) begin
      fails++; $display("FAIL %s%s man actual=%h expected=%h", pre, e.tag, m, e.man);
    end
    if (fl !== efl) begin
      fails++; $display("FAIL %s%s flags actual=%b expected=%b", pre, e.tag, fl, efl);
    end
    if (r !== e.rm) begin
      fails++; $display("FAIL %s%s rm actual=%0d expected=%0d", pre, tr, r, e.rm);
    end
  endtask

  exp_t q32[$];
  exp_t q64[$];

  // Model advance on every edge, compare 1 ns later.
  always @(posedge clk) begin
    exp_t e32, e64;
    bit en;
    en = ce;
    if (!rst_n) begin
      q32.delete(); q64.delete();
    end else if (en) begin
      q32.push_back(model(32, {32'd0, a32}, {32'd0, b32}, rm));
      q64.push_back(model(64, a64, b64, rm));
      if (q32.size() > 5) void'(q32.pop_front());
      if (q64.size() > 5) void'(q64.pop_front());
    end
    #1;
    if (q32.size() == 5) begin
      e32 = q32[0]; e64 = q64[0];
      if (!en) begin e32.tag = "R10"; e64.tag = "R10"; end
    end else begin
      e32 = zero_exp(); e64 = zero_exp();
    end
    chk("", e32, s32, int'($signed(x32)), {58'd0, m32}, {n32, i32, z32, v32}, r32);
    chk("R12/", e64, s64, int'($signed(x64)), m64, {n64, i64, z64, v64}, r64);
  end

  task automatic drive(input logic [31:0] x, input logic [31:0] y,
                       input logic [63:0] xd, input logic [63:0] yd,
                       input logic cen, input logic [2:0] r);
    @(negedge clk);
    a32 = x; b32 = y; a64 = xd; b64 = yd; ce = cen; rm = r;
  endtask

  // Random operand of a chosen class: 0 normal,1 denormal,2 zero,3 inf,4 nan,5 extreme normal
  function automatic logic [63:0] mk(input int fw, input int cls);
    int ew, mw;
    logic [63:0] emax, f, e;
    logic sg;
    ew = (fw == 32) ? 8 : 11;
    mw = fw - 1 - ew;
    emax = (64'd1 << ew) - 1;
    f = {$urandom, $urandom} & ((64'd1 << mw) - 1);
    sg = $urandom % 2;
    case (cls)
      0: e = 1 + ($urandom % (emax - 1));
      1: begin e = 0; if (f == 0) f = 1; end
      2: begin e = 0; f = 0; end
      3: begin e = emax; f = 0; end
      4: begin e = emax; if (f == 0) f = 1; end
      default: e = ($urandom % 2) ? 1 : emax - 1;
    endcase
    return (64'(sg) << (fw - 1)) | (e << mw) | f;
  endfunction

  function automatic int pick();
    int v;
    v = $urandom % 16;
    if (v < 9) return 0;
    if (v < 12) return 1;
    if (v == 12) return 2;
    if (v == 13) return 3;
    if (v == 14) return 4;
    return 5;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2 normals, R4 exponent range, R11 rm pass-through
    drive(32'h3F800000, 32'h3F800000, 64'h3FF0000000000000, 64'h3FF0000000000000, 1, 3'd1);
    drive(32'h3FC00000, 32'hC0000000, 64'h3FF8000000000000, 64'hC000000000000000, 1, 3'd2);
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 1, 3'd7);
    // R3 denormals
    drive(32'h00000001, 32'h00000001, 64'h0000000000000001, 64'h0000000000000001, 1, 3'd3);
    drive(32'h007FFFFF, 32'hBFC00000, 64'h000FFFFFFFFFFFFF, 64'hBFF8000000000000, 1, 3'd4);
    // R6 NaN, R7 inf*zero, R8 inf, R9 zero, R5 sign on specials
    drive(32'h7FC00000, 32'h3F800000, 64'h7FF8000000000000, 64'h3FF0000000000000, 1, 3'd5);
    drive(32'hBF800000, 32'hFF800001, 64'hBFF0000000000000, 64'hFFF0000000000001, 1, 3'd6);
    drive(32'h7F800000, 32'h80000000, 64'h7FF0000000000000, 64'h8000000000000000, 1, 3'd0);
    // R10 stall in the middle of the stream
    drive(32'h00000000, 32'hFF800000, 64'h0000000000000000, 64'hFFF0000000000000, 0, 3'd1);
    drive(32'h00000000, 32'hFF800000, 64'h0000000000000000, 64'hFFF0000000000000, 1, 3'd1);
    drive(32'hFF800000, 32'hC0000000, 64'hFFF0000000000000, 64'hC000000000000000, 1, 3'd2);
    drive(32'h7F800000, 32'h7F800000, 64'h7FF0000000000000, 64'h7FF0000000000000, 0, 3'd2);
    drive(32'h7F800000, 32'h7F800000, 64'h7FF0000000000000, 64'h7FF0000000000000, 1, 3'd2);
    drive(32'h80000000, 32'h40A00000, 64'h8000000000000000, 64'h4014000000000000, 1, 3'd3);
    drive(32'h00000000, 32'h00000001, 64'h0000000000000000, 64'h0000000000000001, 1, 3'd4);
    repeat (3) drive(32'h3F800000, 32'h00400000, 64'h3FF0000000000000, 64'h0008000000000000, 0, 3'd5);
    // Random phase with frequent stalls
    for (int i = 0; i < 600; i++) begin
      logic [63:0] p, q, pd, qd;
      p = mk(32, pick()); q = mk(32, pick());
      pd = mk(64, pick()); qd = mk(64, pick());
      drive(p[31:0], q[31:0], pd, qd, ($urandom % 4) != 0, 3'($urandom));
    end
    // Mid-run reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++)
      drive(32'h40A00000, 32'h00000003, 64'h4014000000000000, 64'h0000000000000003, 1, 3'd6);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule